// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O bank reached through a small memory-mapped register port. Software sets which pins drive, what they drive, and reads the pad levels back. Pad inputs are brought into the clock domain by a two-flop synchronizer before they are read or watched for interrupts.

Every pin has four detection conditions, each enabled by its own read-write register: low level, high level, rising edge and falling edge. Any mix of them may be on at the same time. A matching condition latches the pin's bit in a raw status register. A separate enable register selects which raw bits count toward the masked status and toward the single interrupt output. The enable is changed through a write-one-to-set port and a write-one-to-clear port. Pending bits are acknowledged by writing ones to the masked status register. A zero bit in any of these three writes leaves state unchanged.

Bus accesses are single-cycle 32-bit transfers. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` and `pad_out` are all zero (every pin an input), and `irq_out` is low.
- R2: A write to the direction register (0x134) or the drive register (0x13C) appears on `pad_oe` / `pad_out` after the next clock edge and reads back unchanged. Bit p always belongs to pin p.
- R3: The input register (0x138) returns `pad_in` delayed by two clock edges. A change is not visible after one edge and is visible after two.
- R4: With bit p set in the low-level register (0x140), pin p sets raw status bit p in every cycle its synchronized input is 0.
- R5: With bit p set in the high-level register (0x144), pin p sets raw status bit p in every cycle its synchronized input is 1.
- R6: With bit p set in the rising register (0x148), a 0-to-1 change of the synchronized input sets raw bit p. The bit then stays set after the pin settles.
- R7: With bit p set in the falling register (0x14C), a 1-to-0 change sets raw bit p. With both edge registers set, either change sets it.
- R8: The raw status register (0x24) latches events whatever the enable is. The masked status register (0x2C) reads as raw AND enable.
- R9: Writing ones to 0x34 sets enable bits, and writing ones to 0x3C clears them. Zero bits change nothing. Reads of either address return the enable register.
- R10: Writing a 1 to a bit of 0x2C clears that raw bit, and a 0 bit has no effect. If an event for the same bit arrives in the same cycle as the clear, the bit stays set.
- R11: `irq_out` is the OR of the masked status bits, delayed by one register stage.
- R12: A level-configured pin whose level is still active re-sets its bit after acknowledgment. The acknowledgment holds only once the level is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not selected) |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Drive values |
| pad_oe | output | 32 | Drive enables, 1 = output |
| irq_out | output | 1 | Bank interrupt |

## Verification
The detection logic is tried with several input patterns:
- a single rising step on one pin;
- a pulse on a pin that watches both edges, which tells an edge configuration from a level configuration;
- a held low level and a held high level, which must re-pend after acknowledgment until released;
- a pin toggled with no detection enabled, which must never pend.

Enable writes with zero data and status writes with zero data show that only one bits act. A clear timed into the same cycle as a rising event shows whether the event or the clear wins. Reads of the input register one and two edges after a pad change separate a one-flop path from the two-flop path.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h134;
  localparam logic [ADDR_W-1:0] OFS_DIN   = 12'h138;
  localparam logic [ADDR_W-1:0] OFS_DOUT  = 12'h13C;
  localparam logic [ADDR_W-1:0] OFS_LOW   = 12'h140;
  localparam logic [ADDR_W-1:0] OFS_HIGH  = 12'h144;
  localparam logic [ADDR_W-1:0] OFS_RISE  = 12'h148;
  localparam logic [ADDR_W-1:0] OFS_FALL  = 12'h14C;

  typedef struct packed {
    logic low;
    logic high;
    logic rise;
    logic fall;
  } trig_cfg_t;

  // One pin: does any enabled condition match this cycle?
  function automatic logic pin_hit(trig_cfg_t cfg, logic cur, logic last);
    pin_hit = (cfg.low  & ~cur)
            | (cfg.high &  cur)
            | (cfg.rise &  cur & ~last)
            | (cfg.fall & ~cur &  last);
  endfunction

  // Next raw status: clear is applied first, events override it.
  function automatic logic [DATA_W-1:0] raw_next(logic [DATA_W-1:0] cur,
                                                 logic [DATA_W-1:0] clr,
                                                 logic [DATA_W-1:0] evt);
    raw_next = (cur & ~clr) | evt;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] cfg_low,
  input  logic [W-1:0] cfg_high,
  input  logic [W-1:0] cfg_rise,
  input  logic [W-1:0] cfg_fall,
  output logic [W-1:0] evt
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else last_q <= lvl;
  end

  generate
    for (genvar p = 0; p < W; p++) begin : g_pin
      trig_cfg_t cfg;
      assign cfg = '{low: cfg_low[p], high: cfg_high[p],
                     rise: cfg_rise[p], fall: cfg_fall[p]};
      assign evt[p] = pin_hit(cfg, lvl[p], last_q[p]);
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] stat_clr,
  input  logic [W-1:0] en_set,
  input  logic [W-1:0] en_clr,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] en_q,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_next(raw_q, stat_clr, evt);
      en_q  <= (en_q | en_set) & ~en_clr;
      irq_q <= |(raw_q & en_q);
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe,
  output logic              irq_out
);
  localparam int W = DATA_W;

  logic [W-1:0] dir_q, dout_q, low_q, high_q, rise_q, fall_q;
  logic [W-1:0] lvl_sync, evt, raw_q, en_q;
  logic [W-1:0] stat_clr, en_set, en_clr;
  logic         wr;

  assign wr = bus_sel & bus_we;

  // Write strobes brought out as named wires
  assign stat_clr = (wr && bus_addr == OFS_STAT)  ? bus_wdata : '0;
  assign en_set   = (wr && bus_addr == OFS_ENSET) ? bus_wdata : '0;
  assign en_clr   = (wr && bus_addr == OFS_ENCLR) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      low_q  <= '0;
      high_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr) begin
      unique case (bus_addr)
        OFS_DIR:  dir_q  <= bus_wdata;
        OFS_DOUT: dout_q <= bus_wdata;
        OFS_LOW:  low_q  <= bus_wdata;
        OFS_HIGH: high_q <= bus_wdata;
        OFS_RISE: rise_q <= bus_wdata;
        OFS_FALL: fall_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(lvl_sync)
  );

  gpio_edge_detect #(.W(W)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync),
    .cfg_low(low_q), .cfg_high(high_q), .cfg_rise(rise_q), .cfg_fall(fall_q),
    .evt(evt)
  );

  gpio_irq_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .evt(evt), .stat_clr(stat_clr),
    .en_set(en_set), .en_clr(en_clr), .raw_q(raw_q), .en_q(en_q),
    .irq_q(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (bus_addr)
        OFS_RAW:   bus_rdata = raw_q;
        OFS_STAT:  bus_rdata = raw_q & en_q;
        OFS_ENSET: bus_rdata = en_q;
        OFS_ENCLR: bus_rdata = en_q;
        OFS_DIR:   bus_rdata = dir_q;
        OFS_DIN:   bus_rdata = lvl_sync;
        OFS_DOUT:  bus_rdata = dout_q;
        OFS_LOW:   bus_rdata = low_q;
        OFS_HIGH:  bus_rdata = high_q;
        OFS_RISE:  bus_rdata = rise_q;
        OFS_FALL:  bus_rdata = fall_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] evt,
  input logic [DATA_W-1:0] stat_clr,
  input logic [DATA_W-1:0] en_set,
  input logic [DATA_W-1:0] en_clr,
  input logic [DATA_W-1:0] raw_q,
  input logic [DATA_W-1:0] en_q,
  input logic [DATA_W-1:0] pad_oe,
  input logic              irq_out
);
  // R10: an event in a cycle always leaves its raw bit set, clear or not
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(evt)) == $past(evt)));

  // R10: raw bits drop only where a one was written to the status register
  assert_no_silent_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(raw_q) & ~raw_q) & ~$past(stat_clr)) == '0));

  // R9: set bits are on after a set write (when not cleared together)
  assert_enable_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set != '0 && en_clr == '0) |=> ((en_q & $past(en_set)) == $past(en_set)));

  // R9: cleared bits are off after a clear write
  assert_enable_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr != '0) |=> ((en_q & $past(en_clr)) == '0));

  // R9: enable bits never change without a write
  assert_enable_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set == '0 && en_clr == '0) |=> $stable(en_q));

  // R11: any masked pending bit raises the interrupt one cycle later
  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & en_q) != '0) |=> irq_out);

  // R11: no masked pending bit means the interrupt drops one cycle later
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & en_q) == '0) |=> !irq_out);

  // R1: state during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!irq_out || $isunknown(irq_out));
    end
  end
endmodule

bind gpio_irq_bank gpio_irq_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .stat_clr(stat_clr),
  .en_set(en_set), .en_clr(en_clr), .raw_q(raw_q), .en_q(en_q),
  .pad_oe(pad_oe), .irq_out(irq_out)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  import gpio_irq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [DATA_W-1:0] pad_in = '0;
  logic [DATA_W-1:0] pad_out, pad_oe;
  logic              irq_out;

  int checks = 0;
  int errors = 0;

  gpio_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rdchk(string req, logic [ADDR_W-1:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // Return to a quiet bank: no detection, no enables, no pending bits
  task automatic quiet();
    wr(OFS_LOW, '0); wr(OFS_HIGH, '0); wr(OFS_RISE, '0); wr(OFS_FALL, '0);
    wr(OFS_ENCLR, '1);
    cyc(4);
    wr(OFS_STAT, '1);
    cyc(2);
  endtask

  task automatic t_reset();
    rdchk("R1 raw", OFS_RAW, 0);
    rdchk("R1 stat", OFS_STAT, 0);
    rdchk("R1 enable", OFS_ENSET, 0);
    rdchk("R1 dir", OFS_DIR, 0);
    rdchk("R1 low", OFS_LOW, 0);
    rdchk("R1 rise", OFS_RISE, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq_out", {31'b0, irq_out}, 0);
  endtask

  task automatic t_io();
    wr(OFS_DIR, 32'hF0F0_0000);
    wr(OFS_DOUT, 32'h1234_5678);
    chk("R2 pad_oe", pad_oe, 32'hF0F0_0000);
    chk("R2 pad_out", pad_out, 32'h1234_5678);
    rdchk("R2 dir readback", OFS_DIR, 32'hF0F0_0000);
    rdchk("R2 dout readback", OFS_DOUT, 32'h1234_5678);
    pad_in = 32'hA5A5_0001;
    cyc(1);
    rdchk("R3 din after one edge", OFS_DIN, 32'h0);
    cyc(1);
    rdchk("R3 din after two edges", OFS_DIN, 32'hA5A5_0001);
    // no detection configured: toggling pins pends nothing (R8)
    pad_in = 32'h0;
    cyc(4);
    rdchk("R8 unconfigured pins stay idle", OFS_RAW, 0);
  endtask

  task automatic t_rise();
    wr(OFS_RISE, 32'h0000_0008);
    pad_in[3] = 1'b1;
    cyc(4);
    rdchk("R6 rising sets raw bit 3", OFS_RAW, 32'h8);
    rdchk("R8 masked status zero while disabled", OFS_STAT, 0);
    chk("R11 irq low while disabled", {31'b0, irq_out}, 0);
    wr(OFS_STAT, 32'h8);
    cyc(3);
    rdchk("R6 steady high does not re-pend", OFS_RAW, 0);
    pad_in[3] = 1'b0;
    cyc(4);
    rdchk("R6 falling ignored on rise-only pin", OFS_RAW, 0);
    pad_in[3] = 1'b1;
    cyc(4);
    wr(OFS_ENSET, 32'h8);
    rdchk("R8 masked status after enable", OFS_STAT, 32'h8);
    chk("R11 irq lags one stage", {31'b0, irq_out}, 0);
    cyc(1);
    chk("R11 irq high", {31'b0, irq_out}, 1);
    wr(OFS_ENCLR, 32'h8);
    cyc(1);
    chk("R11 irq low after disable", {31'b0, irq_out}, 0);
    rdchk("R8 raw kept after disable", OFS_RAW, 32'h8);
    pad_in[3] = 1'b0;
    quiet();
  endtask

  task automatic t_both_edges();
    wr(OFS_RISE, 32'h80);
    wr(OFS_FALL, 32'h80);
    pad_in[7] = 1'b1;
    cyc(4);
    rdchk("R7 both-edge pin on rise", OFS_RAW, 32'h80);
    wr(OFS_STAT, 32'h80);
    cyc(2);
    rdchk("R10 ack clears", OFS_RAW, 0);
    pad_in[7] = 1'b0;
    cyc(4);
    rdchk("R7 both-edge pin on fall", OFS_RAW, 32'h80);
    quiet();
    wr(OFS_FALL, 32'h80);
    pad_in[7] = 1'b1;
    cyc(4);
    rdchk("R7 fall-only ignores rise", OFS_RAW, 0);
    pad_in[7] = 1'b0;
    cyc(4);
    rdchk("R7 fall-only sees fall", OFS_RAW, 32'h80);
    quiet();
  endtask

  task automatic t_levels();
    // pin 10 low-level, input already 0
    wr(OFS_LOW, 32'h400);
    cyc(2);
    rdchk("R4 low level pends", OFS_RAW, 32'h400);
    wr(OFS_STAT, 32'h400);
    cyc(1);
    rdchk("R12 low level re-pends after ack", OFS_RAW, 32'h400);
    pad_in[10] = 1'b1;
    cyc(4);
    wr(OFS_STAT, 32'h400);
    cyc(3);
    rdchk("R12 ack holds once level gone", OFS_RAW, 0);
    wr(OFS_LOW, 0);
    pad_in[10] = 1'b0;
    // pin 12 high-level
    wr(OFS_HIGH, 32'h1000);
    cyc(3);
    rdchk("R5 high level idle while low", OFS_RAW, 0);
    pad_in[12] = 1'b1;
    cyc(4);
    rdchk("R5 high level pends", OFS_RAW, 32'h1000);
    wr(OFS_STAT, 32'h1000);
    cyc(1);
    rdchk("R12 high level re-pends", OFS_RAW, 32'h1000);
    pad_in[12] = 1'b0;
    quiet();
  endtask

  task automatic t_enable_w1();
    wr(OFS_ENSET, 32'h5);
    wr(OFS_ENSET, 32'h0);
    rdchk("R9 zero set write no effect", OFS_ENSET, 32'h5);
    wr(OFS_ENCLR, 32'h1);
    rdchk("R9 clear one bit", OFS_ENCLR, 32'h4);
    wr(OFS_ENCLR, 32'h0);
    rdchk("R9 zero clear write no effect", OFS_ENSET, 32'h4);
    wr(OFS_ENCLR, 32'h4);
  endtask

  task automatic t_stat_w1c();
    wr(OFS_RISE, 32'h3);
    pad_in[1:0] = 2'b11;
    cyc(4);
    wr(OFS_STAT, 32'h0);
    rdchk("R10 zero status write no effect", OFS_RAW, 32'h3);
    wr(OFS_STAT, 32'h1);
    rdchk("R10 one bit cleared only", OFS_RAW, 32'h2);
    quiet();
    // event and clear in the same cycle on pin 5
    wr(OFS_RISE, 32'h20);
    pad_in[5] = 1'b1;          // before edge k
    @(posedge clk);            // k: first flop
    @(posedge clk);            // k+1: synchronized, event this cycle
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = OFS_STAT; bus_wdata = 32'h20;
    @(posedge clk);            // k+2: clear and event together
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rdchk("R10 event wins over clear", OFS_RAW, 32'h20);
    pad_in = '0;
    quiet();
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_io();
    t_rise();
    t_both_edges();
    t_levels();
    t_enable_w1();
    t_stat_w1c();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule